// File: doc/BRIEF.md
# Display Run/Stop and Configuration Shadow Controller

This block is the control and interrupt core of a display processor. Software starts and stops scan-out through a control register, chooses between a continuously streaming video interface and a frame-on-demand command interface, and owns a pending configuration word. The block decides when the pending word reaches the working copy that the pixel pipeline uses.

In video mode the working copy is shadowed. Software posts an update request while the display runs, and the copy takes place at the next frame boundary so that no frame is torn. In command mode the working copy is not shadowed. It is loaded only when run goes from 0 to 1, and each run covers exactly one frame transfer. Each completion event, the tearing-effect edge and the video frame boundary set their own sticky interrupt status bit. These bits are masked into a single interrupt line.

Top module: `disp_runctl`

## Requirements
- R1: After reset every register reads 0, and `running`, `irq` and `cfg_work` are 0.
- R2: In the control register (offset 0x004), a written bit 0 requests run, bit 1 requests stop and bit 2 requests an update. A read returns the run state in bit 0, a pending stop in bit 1 and a pending update in bit 2.
- R3: Bit 0 of the mode register (offset 0x008) selects command mode when 1 and video mode when 0. A write to this register while running is ignored.
- R4: A run request made while stopped sets `running` and copies the pending configuration (offset 0x020) into `cfg_work` in the same cycle, in either mode. A run request made while already running does not reload `cfg_work`.
- R5: In video mode, while running, an update request is held pending until the next `frame_tick`. At that tick `cfg_work` takes the pending word, the request clears itself and status bit 4 sets. An update request made in command mode or while stopped has no effect.
- R6: In command mode, `cfg_work` does not change while running. A `frame_done` pulse ends the run and sets status bit 0.
- R7: In video mode, a stop request is held pending while running. At the next `frame_tick`, `running` drops and status bit 0 sets.
- R8: Each `frame_tick` in video mode while running sets status bit 5. Ticks in command mode set nothing.
- R9: In the interface register (offset 0x1F0), bit 8 enables the tearing-effect input and bit 10 selects `te_pad` (1) or `te_alt` (0). A rising edge of the selected source while enabled sets status bit 1. Edges on the unselected source, or while disabled, set nothing.
- R10: Status (offset 0x1E8, read-only) is sticky. Writing 1 to a bit of the clear register (offset 0x1E4) clears that bit. Enable lives at offset 0x1E0. `irq` is 1 whenever any status bit is set together with its enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| frame_tick | input | 1 | Frame-boundary strobe from the timing generator |
| frame_done | input | 1 | End-of-transfer strobe for a command-mode frame |
| te_pad | input | 1 | Tearing-effect signal from the external pad |
| te_alt | input | 1 | Alternate tearing-effect source |
| running | output | 1 | Scan-out active |
| cfg_work | output | CFG_W | Working configuration driven to the pipeline |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench builds the block with its defaults: a 12-bit offset, a 32-bit data word and a 16-bit configuration word. These are wide enough to place distinct patterns in the pending and working copies, so a copy made at the wrong moment shows up as a wrong value. Frame ticks and done pulses are driven by hand. This lets the bench hold a posted update or stop across several idle cycles and confirm that nothing moves before the boundary, and that a tick in command mode does nothing.

// File: rtl/disp_pkg.sv
package disp_pkg;
    localparam int NB_IRQ    = 6;
    localparam int IRQ_DONE  = 0;
    localparam int IRQ_TE    = 1;
    localparam int IRQ_UPD   = 4;
    localparam int IRQ_VSYNC = 5;
    localparam logic [NB_IRQ-1:0] IRQ_IMPL = 6'b110011;

    typedef struct packed {
        logic run;
        logic stop_pend;
        logic upd_pend;
        logic cmd_mode;
        logic te_en;
        logic te_ext;
    } ctl_t;
endpackage

// File: rtl/disp_te_detect.sv
module disp_te_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic te_en,
    input  logic te_ext,
    input  logic te_pad,
    input  logic te_alt,
    output logic te_pulse
);
    logic sel;
    logic prev_d, prev_q;

    always_comb begin
        sel      = te_ext ? te_pad : te_alt;
        prev_d   = sel;
        te_pulse = te_en & sel & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/disp_irq_ctrl.sv
module disp_irq_ctrl #(
    parameter int          NB   = 6,
    parameter logic [NB-1:0] IMPL = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] set_vec,
    input  logic          en_wr,
    input  logic          clr_wr,
    input  logic [NB-1:0] wdata,
    output logic [NB-1:0] en_q,
    output logic [NB-1:0] sts_q,
    output logic          irq
);
    logic [NB-1:0] en_d, sts_d;

    always_comb begin
        en_d  = en_wr ? (wdata & IMPL) : en_q;
        sts_d = sts_q;
        if (clr_wr) sts_d = sts_d & ~wdata;
        sts_d = (sts_d | set_vec) & IMPL;
        irq   = |(sts_q & en_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            sts_q <= '0;
        end else begin
            en_q  <= en_d;
            sts_q <= sts_d;
        end
    end
endmodule

// File: rtl/disp_runctl.sv
module disp_runctl
    import disp_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int CFG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              frame_tick,
    input  logic              frame_done,
    input  logic              te_pad,
    input  logic              te_alt,
    output logic              running,
    output logic [CFG_W-1:0]  cfg_work,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(12'h004);
    localparam logic [ADDR_W-1:0] OFF_MODE = ADDR_W'(12'h008);
    localparam logic [ADDR_W-1:0] OFF_CFG  = ADDR_W'(12'h020);
    localparam logic [ADDR_W-1:0] OFF_IEN  = ADDR_W'(12'h1E0);
    localparam logic [ADDR_W-1:0] OFF_ICLR = ADDR_W'(12'h1E4);
    localparam logic [ADDR_W-1:0] OFF_ISTS = ADDR_W'(12'h1E8);
    localparam logic [ADDR_W-1:0] OFF_IFC  = ADDR_W'(12'h1F0);
    localparam int BIT_TE_EN  = 8;
    localparam int BIT_TE_EXT = 10;

    typedef struct packed {
        ctl_t             c;
        logic [CFG_W-1:0] pend;
        logic [CFG_W-1:0] work;
    } st_t;

    st_t s_d, s_q;
    logic [NB_IRQ-1:0] sts_set, int_en, int_sts;
    logic ctrl_wr, mode_wr, cfg_wr, ifc_wr, en_wr, clr_wr;
    logic te_pulse;
    logic unused_wdata;

    assign unused_wdata = ^bus_wdata;

    always_comb begin
        ctrl_wr = bus_wr && (bus_addr == OFF_CTRL);
        mode_wr = bus_wr && (bus_addr == OFF_MODE);
        cfg_wr  = bus_wr && (bus_addr == OFF_CFG);
        ifc_wr  = bus_wr && (bus_addr == OFF_IFC);
        en_wr   = bus_wr && (bus_addr == OFF_IEN);
        clr_wr  = bus_wr && (bus_addr == OFF_ICLR);

        s_d     = s_q;
        sts_set = '0;
        sts_set[IRQ_TE] = te_pulse;

        if (s_q.c.run) begin
            if (!s_q.c.cmd_mode) begin
                if (frame_tick) begin
                    sts_set[IRQ_VSYNC] = 1'b1;
                    if (s_q.c.upd_pend) begin
                        s_d.work        = s_q.pend;
                        s_d.c.upd_pend  = 1'b0;
                        sts_set[IRQ_UPD] = 1'b1;
                    end
                    if (s_q.c.stop_pend) begin
                        s_d.c.run       = 1'b0;
                        s_d.c.stop_pend = 1'b0;
                        s_d.c.upd_pend  = 1'b0;
                        sts_set[IRQ_DONE] = 1'b1;
                    end
                end
                if (ctrl_wr && bus_wdata[2] && s_d.c.run) s_d.c.upd_pend  = 1'b1;
                if (ctrl_wr && bus_wdata[1] && s_d.c.run) s_d.c.stop_pend = 1'b1;
            end else if (frame_done) begin
                s_d.c.run = 1'b0;
                sts_set[IRQ_DONE] = 1'b1;
            end
        end else if (ctrl_wr && bus_wdata[0]) begin
            s_d.c.run = 1'b1;
            s_d.work  = s_q.pend;
        end

        if (mode_wr && !s_q.c.run) s_d.c.cmd_mode = bus_wdata[0];
        if (cfg_wr) s_d.pend = bus_wdata[CFG_W-1:0];
        if (ifc_wr) begin
            s_d.c.te_en  = bus_wdata[BIT_TE_EN];
            s_d.c.te_ext = bus_wdata[BIT_TE_EXT];
        end

        bus_rdata = '0;
        case (bus_addr)
            OFF_CTRL: bus_rdata[2:0] = {s_q.c.upd_pend, s_q.c.stop_pend, s_q.c.run};
            OFF_MODE: bus_rdata[0] = s_q.c.cmd_mode;
            OFF_CFG:  bus_rdata[CFG_W-1:0] = s_q.pend;
            OFF_IEN:  bus_rdata[NB_IRQ-1:0] = int_en;
            OFF_ISTS: bus_rdata[NB_IRQ-1:0] = int_sts;
            OFF_IFC: begin
                bus_rdata[BIT_TE_EN]  = s_q.c.te_en;
                bus_rdata[BIT_TE_EXT] = s_q.c.te_ext;
            end
            default: bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign running  = s_q.c.run;
    assign cfg_work = s_q.work;

    disp_te_detect u_te (
        .clk      (clk),
        .rst_n    (rst_n),
        .te_en    (s_q.c.te_en),
        .te_ext   (s_q.c.te_ext),
        .te_pad   (te_pad),
        .te_alt   (te_alt),
        .te_pulse (te_pulse)
    );

    disp_irq_ctrl #(.NB(NB_IRQ), .IMPL(IRQ_IMPL)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (sts_set),
        .en_wr   (en_wr),
        .clr_wr  (clr_wr),
        .wdata   (bus_wdata[NB_IRQ-1:0]),
        .en_q    (int_en),
        .sts_q   (int_sts),
        .irq     (irq)
    );
endmodule

// File: rtl/disp_runctl_chk.sv
module disp_runctl_chk #(
    parameter int CFG_W = 16,
    parameter int NB    = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_tick,
    input logic             frame_done,
    input logic             running,
    input logic             cmd_mode,
    input logic [CFG_W-1:0] cfg_work,
    input logic [NB-1:0]    int_sts,
    input logic             clr_wr,
    input logic             clr_bit0
);
    // R4 / R5: working copy moves only on a run start or a frame boundary
    a_r5_copy_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_work) |-> ($past(frame_tick) || $rose(running)));

    // R6: command mode holds the working copy for the whole run
    a_r6_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running) && cmd_mode) |-> $stable(cfg_work));

    // R6 / R7: a run ends only at a frame boundary or a done strobe
    a_r7_end_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> ($past(frame_tick) || $past(frame_done)));

    // R7: the end of a run is always flagged
    a_r7_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> int_sts[0]);

    // R10: the done flag is sticky until cleared
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(int_sts[0]) && !($past(clr_wr) && $past(clr_bit0))) |-> int_sts[0]);
endmodule

bind disp_runctl disp_runctl_chk #(.CFG_W(CFG_W), .NB(disp_pkg::NB_IRQ)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_tick (frame_tick),
    .frame_done (frame_done),
    .running    (running),
    .cmd_mode   (s_q.c.cmd_mode),
    .cfg_work   (cfg_work),
    .int_sts    (int_sts),
    .clr_wr     (clr_wr),
    .clr_bit0   (bus_wdata[0])
);

// File: tb/disp_runctl_tb.sv
module disp_runctl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        frame_tick = 1'b0, frame_done = 1'b0, te_pad = 1'b0, te_alt = 1'b0;
    logic        running, irq;
    logic [15:0] cfg_work;
    int n_chk = 0, n_fail = 0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    disp_runctl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_tick(frame_tick),
        .frame_done(frame_done), .te_pad(te_pad), .te_alt(te_alt),
        .running(running), .cfg_work(cfg_work), .irq(irq)
    );

    localparam logic [3:0] OP_W = 0, OP_R = 1, OP_T = 2, OP_D = 3, OP_P = 4;
    localparam int NV = 41;
    // {op, req, offset, data-or-expected}
    localparam logic [51:0] VEC [NV] = '{
        {OP_W, 4'd4,  12'h020, 32'h1111}, {OP_W, 4'd10, 12'h1E0, 32'h3F},
        {OP_W, 4'd4,  12'h004, 32'h1},    {OP_P, 4'd4,  12'h000, 32'h1111},   // R4 load on start
        {OP_R, 4'd2,  12'h004, 32'h1},    {OP_W, 4'd5,  12'h020, 32'h2222},
        {OP_P, 4'd5,  12'h000, 32'h1111}, {OP_W, 4'd5,  12'h004, 32'h4},      // R5 request
        {OP_R, 4'd2,  12'h004, 32'h5},    {OP_P, 4'd5,  12'h000, 32'h1111},   // R2 readback
        {OP_T, 4'd5,  12'h000, 32'h0},    {OP_P, 4'd5,  12'h000, 32'h2222},   // R5 copy at tick
        {OP_R, 4'd5,  12'h004, 32'h1},    {OP_R, 4'd8,  12'h1E8, 32'h30},     // R8 vsync + upd
        {OP_W, 4'd10, 12'h1E4, 32'h10},   {OP_R, 4'd10, 12'h1E8, 32'h20},     // R10 w1c
        {OP_W, 4'd3,  12'h008, 32'h1},    {OP_R, 4'd3,  12'h008, 32'h0},      // R3 ignored
        {OP_W, 4'd7,  12'h004, 32'h2},    {OP_R, 4'd7,  12'h004, 32'h3},      // R7 pending
        {OP_T, 4'd7,  12'h000, 32'h0},    {OP_R, 4'd7,  12'h004, 32'h0},
        {OP_R, 4'd7,  12'h1E8, 32'h21},   {OP_W, 4'd10, 12'h1E4, 32'h3F},
        {OP_R, 4'd10, 12'h1E8, 32'h0},    {OP_W, 4'd3,  12'h008, 32'h1},
        {OP_R, 4'd3,  12'h008, 32'h1},    {OP_W, 4'd4,  12'h020, 32'h3333},
        {OP_W, 4'd4,  12'h004, 32'h1},    {OP_P, 4'd4,  12'h000, 32'h3333},
        {OP_W, 4'd6,  12'h020, 32'h4444}, {OP_W, 4'd5,  12'h004, 32'h4},      // R5 no effect in cmd
        {OP_R, 4'd5,  12'h004, 32'h1},    {OP_T, 4'd8,  12'h000, 32'h0},
        {OP_P, 4'd6,  12'h000, 32'h3333}, {OP_R, 4'd8,  12'h1E8, 32'h0},      // R6 hold, R8 none
        {OP_D, 4'd6,  12'h000, 32'h0},    {OP_R, 4'd6,  12'h004, 32'h0},
        {OP_R, 4'd6,  12'h1E8, 32'h1},    {OP_W, 4'd4,  12'h004, 32'h1},
        {OP_P, 4'd4,  12'h000, 32'h4444}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk); bus_addr = a; #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic pulse_tick();
        @(negedge clk); frame_tick = 1'b1; @(negedge clk); frame_tick = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); frame_done = 1'b1; @(negedge clk); frame_done = 1'b0;
    endtask

    initial begin
        #2000000;
        if (!done_flag) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd("R1", 12'h004, 32'h0);
        rd("R1", 12'h1E8, 32'h0);
        check("R1", {29'h0, running, irq, 1'b0}, 32'h0);
        check("R1", {16'h0, cfg_work}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [3:0] op, rq;
            logic [11:0] ad;
            logic [31:0] dv;
            string tag;
            {op, rq, ad, dv} = VEC[i];
            tag = $sformatf("R%0d vec%0d", rq, i);
            case (op)
                OP_W: wr(ad, dv);
                OP_R: rd(tag, ad, dv);
                OP_T: pulse_tick();
                OP_D: pulse_done();
                default: begin @(negedge clk); check(tag, {16'h0, cfg_work}, dv); end
            endcase
        end

        // R4 start while running does not reload (command mode, running)
        wr(12'h020, 32'h5555);
        wr(12'h004, 32'h1);
        @(negedge clk); check("R4 no reload", {16'h0, cfg_work}, 32'h4444);

        // R10 irq masking: status bit0 set, all enabled
        @(negedge clk); check("R10 irq on", {31'h0, irq}, 32'h1);
        wr(12'h1E0, 32'h0);
        @(negedge clk); check("R10 irq masked", {31'h0, irq}, 32'h0);
        wr(12'h1E4, 32'h3F);
        rd("R10 cleared", 12'h1E8, 32'h0);

        // R9 tearing effect: pad selected
        wr(12'h1F0, 32'h500);
        rd("R9 ifc readback", 12'h1F0, 32'h500);
        @(negedge clk); te_alt = 1'b1; @(negedge clk); @(negedge clk); te_alt = 1'b0;
        rd("R9 alt ignored", 12'h1E8, 32'h0);
        @(negedge clk); te_pad = 1'b1; @(negedge clk); @(negedge clk); te_pad = 1'b0;
        rd("R9 pad edge", 12'h1E8, 32'h2);
        wr(12'h1E4, 32'h2);
        // R9 alternate selected
        wr(12'h1F0, 32'h100);
        @(negedge clk); te_alt = 1'b1; @(negedge clk); @(negedge clk); te_alt = 1'b0;
        rd("R9 alt edge", 12'h1E8, 32'h2);
        wr(12'h1E4, 32'h2);
        // R9 disabled
        wr(12'h1F0, 32'h400);
        @(negedge clk); te_pad = 1'b1; @(negedge clk); @(negedge clk); te_pad = 1'b0;
        rd("R9 disabled", 12'h1E8, 32'h0);

        done_flag = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule